// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Hardware Traps

This block gathers requests from 32 peripheral sources and from eight hardware trap conditions, and decides which one, if any, is offered to the processor. It outputs the winning request's trap number and vector address. Each peripheral source has its own control word. The word holds a pending flag, an enable flag and a priority level from 0 to 15. Software programs the word through a simple write port, and a peripheral raises the flag with a one-cycle event pulse.

The controller tracks the level at which the processor currently runs. A peripheral request is offered only when its level is strictly above that running level. When the processor acknowledges a request, the controller clears the matching pending state, saves the old running level on a small stack and raises the running level. A return pops the stack.

Hardware traps cannot be masked, and they rank above every peripheral level. There are two trap groups:
- Urgent traps (external non-maskable interrupt, stack overflow, stack underflow) each have their own vector.
- Program-fault traps (undefined opcode, protected instruction, illegal operand access, illegal instruction access, illegal bus access) share one vector. Software tells them apart by reading the sticky trap flag register.

Top module: `ic_ctrl`

## Requirements
- R1: After reset all control words read 0, no request is offered (irq_req=0), cpu_prio is 0 and trap_flags is 0.
- R2: A write stores a control word as bit 7 = pending, bit 6 = enable, bits 3:0 = level. Bits 5:4 always read as 0. reg_rdata shows the word of the source selected by reg_addr in the same cycle.
- R3: A src_evt pulse sets that source's pending flag at the next edge. A pending source whose enable bit is 0 keeps its flag but is never offered.
- R4: Among enabled pending sources the highest level wins. On a tie, the lower source index wins.
- R5: A peripheral request is offered only if its level is strictly greater than cpu_prio. Level 0 is therefore never offered at cpu_prio 0.
- R6: For source i the trap number is 0x10+i. The vector is always trap number × 4, so sources span vectors 0x40 to 0xBC.
- R7: An acknowledge (irq_ack while irq_req=1) clears the offered source's pending flag, pushes the old cpu_prio and loads cpu_prio with the source's level. irq_ack with irq_req=0 has no effect.
- R8: irq_ret restores the previously pushed cpu_prio. irq_ret with an empty stack, or in the same cycle as an acknowledge, has no effect.
- R9: The urgent traps are trap_evt bits 0, 1 and 2, with trap numbers 2, 4 and 6 and vectors 0x08, 0x10 and 0x18. They are offered above any peripheral request. Among them the lowest bit wins. Acknowledging one sets cpu_prio to 17 and clears only that trap's pending state.
- R10: The program-fault traps are trap_evt bits 3 to 7. Any of them offers trap number 0x0A, vector 0x28. Acknowledging clears all five pending states and sets cpu_prio to 16. While cpu_prio is 16 or 17 no peripheral request is offered. An urgent trap preempts a program-fault service, but a trap is never offered during a service of its own group or a higher one.
- R11: Each trap_evt bit sets the same bit of trap_flags. The bit stays set until a 1 is written to the same bit of trap_clr. If an event and a clear hit the same bit in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_addr | input | 5 | Source index for write and read |
| reg_wdata | input | 8 | Control word to write |
| reg_rdata | output | 8 | Control word of the addressed source |
| src_evt | input | 32 | Per-source event pulses |
| trap_evt | input | 8 | Hardware trap condition pulses |
| trap_clr | input | 8 | Write-one-to-clear for trap_flags |
| trap_flags | output | 8 | Sticky trap flag register |
| irq_ack | input | 1 | Processor accepts the offered request |
| irq_ret | input | 1 | Processor returns from a service |
| irq_req | output | 1 | A request is offered |
| irq_is_trap | output | 1 | Offered request is a hardware trap |
| irq_num | output | 6 | Trap number of the offered request |
| irq_vec | output | 8 | Vector address of the offered request |
| cpu_prio | output | 5 | Running level: 0-15 peripheral, 16 fault trap, 17 urgent trap |

## Verification
The hardest situation to reach is a nested chain in which an urgent trap preempts a program-fault service, and a further fault event then arrives that must stay hidden until both levels unwind. The bench builds this from the ports. It acknowledges a fault trap, pulses an urgent trap, acknowledges it, pulses another fault condition, and then steps irq_ret one level at a time while checking cpu_prio and the offer after each step. Ties and disabled-but-pending sources are reached from a vector table of control word writes. Each write in the table is followed by a check of which trap number is offered.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int TRAP_N    = 8;   // trap condition inputs
  localparam int URGENT_N  = 3;   // low bits: urgent group with own vectors
  localparam int FAULT_NUM = 10;  // shared number of the fault group
  localparam int TNUM_W    = 4;   // width of a trap number (all < 16)
  localparam int SRC_BASE  = 16;  // first peripheral trap number

  // trap number of urgent trap i: 2, 4, 6 ...
  function automatic logic [TNUM_W-1:0] urgent_num(input int i);
    return TNUM_W'(2 * (i + 1));
  endfunction
endpackage

// File: rtl/ic_src_bank.sv
module ic_src_bank #(
  parameter int NSRC  = 32,
  parameter int LVL_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_pend,
  input  logic                        wr_ena,
  input  logic [LVL_W-1:0]            wr_lvl,
  input  logic [NSRC-1:0]             evt,
  input  logic                        clr_en,
  input  logic [IDX_W-1:0]            clr_idx,
  output logic [NSRC-1:0]             pend,
  output logic [NSRC-1:0]             ena,
  output logic [NSRC-1:0][LVL_W-1:0]  lvl
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic             pend_q, pend_d;
    logic             ena_q,  ena_d;
    logic [LVL_W-1:0] lvl_q,  lvl_d;
    logic             hit_wr, hit_clr;

    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(i));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(i));

    // ordering: acknowledge clear, then software write, then event
    always_comb begin
      pend_d = pend_q;
      ena_d  = ena_q;
      lvl_d  = lvl_q;
      if (hit_clr) pend_d = 1'b0;
      if (hit_wr) begin
        pend_d = wr_pend;
        ena_d  = wr_ena;
        lvl_d  = wr_lvl;
      end
      if (evt[i]) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        ena_q  <= 1'b0;
        lvl_q  <= '0;
      end else begin
        pend_q <= pend_d;
        ena_q  <= ena_d;
        lvl_q  <= lvl_d;
      end
    end

    assign pend[i] = pend_q;
    assign ena[i]  = ena_q;
    assign lvl[i]  = lvl_q;
  end
endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
  parameter int NSRC  = 32,
  parameter int LVL_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             pend,
  input  logic [NSRC-1:0]             ena,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
  output logic                        found,
  output logic [IDX_W-1:0]            win_idx,
  output logic [LVL_W-1:0]            win_lvl
);
  // ascending scan with strict compare keeps the lower index on ties
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && ena[i] && (!found || (lvl[i] > win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/ic_trap_unit.sv
module ic_trap_unit
  import ic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TRAP_N-1:0]    evt,
  input  logic [TRAP_N-1:0]    clr,
  input  logic                 ack,
  output logic [TRAP_N-1:0]    flags,
  output logic                 found,
  output logic                 is_urgent,
  output logic [TNUM_W-1:0]    num
);
  localparam int FAULT_N = TRAP_N - URGENT_N;

  logic [TRAP_N-1:0]   pend_q, pend_d;
  logic [TRAP_N-1:0]   flag_q, flag_d;
  logic [URGENT_N-1:0] u_hit, u_low;
  logic                f_hit;
  logic [TRAP_N-1:0]   ack_mask;

  assign u_hit     = pend_q[URGENT_N-1:0];
  assign f_hit     = |pend_q[TRAP_N-1:URGENT_N];
  assign u_low     = u_hit & (~u_hit + URGENT_N'(1));
  assign found     = (|u_hit) | f_hit;
  assign is_urgent = |u_hit;

  always_comb begin
    num = TNUM_W'(FAULT_NUM);
    for (int i = URGENT_N - 1; i >= 0; i--) begin
      if (u_hit[i]) num = urgent_num(i);
    end
  end

  always_comb begin
    ack_mask = '0;
    if (ack) begin
      if (is_urgent) ack_mask = {{FAULT_N{1'b0}}, u_low};
      else           ack_mask = {{FAULT_N{1'b1}}, {URGENT_N{1'b0}}};
    end
    pend_d = (pend_q & ~ack_mask) | evt;
    flag_d = (flag_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      flag_q <= '0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/ic_prio_stack.sv
module ic_prio_stack #(
  parameter int W     = 5,
  parameter int DEPTH = 20,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d;
  logic          do_push, do_pop;
  logic [AW-1:0] top_idx, wr_idx;

  assign do_push = push && (ptr_q < PW'(DEPTH));
  assign do_pop  = pop && !push && (ptr_q != '0);
  assign empty   = (ptr_q == '0);
  assign top_idx = empty ? '0 : AW'(ptr_q - PW'(1));
  assign wr_idx  = AW'(ptr_q);
  assign dout    = mem_q[top_idx];

  always_comb begin
    ptr_d = ptr_q;
    if (do_push)     ptr_d = ptr_q + PW'(1);
    else if (do_pop) ptr_d = ptr_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_idx] <= din;
  end
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int LVL_W     = 4,
  parameter int STK_DEPTH = 20,
  localparam int IDX_W = $clog2(NSRC),
  localparam int CW    = LVL_W + 4,
  localparam int NUM_W = $clog2(SRC_BASE + NSRC),
  localparam int RW    = LVL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [IDX_W-1:0]   reg_addr,
  input  logic [CW-1:0]      reg_wdata,
  output logic [CW-1:0]      reg_rdata,
  input  logic [NSRC-1:0]    src_evt,
  input  logic [TRAP_N-1:0]  trap_evt,
  input  logic [TRAP_N-1:0]  trap_clr,
  output logic [TRAP_N-1:0]  trap_flags,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_req,
  output logic               irq_is_trap,
  output logic [NUM_W-1:0]   irq_num,
  output logic [NUM_W+1:0]   irq_vec,
  output logic [RW-1:0]      cpu_prio
);
  localparam logic [RW-1:0] FAULT_LVL  = RW'(2 ** LVL_W);
  localparam logic [RW-1:0] URGENT_LVL = FAULT_LVL + RW'(1);

  logic [NSRC-1:0]            s_pend, s_ena;
  logic [NSRC-1:0][LVL_W-1:0] s_lvl;
  logic                       a_found;
  logic [IDX_W-1:0]           a_idx;
  logic [LVL_W-1:0]           a_lvl;
  logic                       t_found, t_urgent;
  logic [TNUM_W-1:0]          t_num;
  logic                       pick_trap;
  logic [RW-1:0]              pick_lvl;
  logic                       take, do_ret;
  logic [RW-1:0]              stk_top;
  logic                       stk_empty;
  logic [RW-1:0]              prio_q, prio_d;

  ic_src_bank #(.NSRC(NSRC), .LVL_W(LVL_W)) u_bank (
    .clk, .rst_n,
    .wr_en   (reg_wr),
    .wr_idx  (reg_addr),
    .wr_pend (reg_wdata[CW-1]),
    .wr_ena  (reg_wdata[CW-2]),
    .wr_lvl  (reg_wdata[LVL_W-1:0]),
    .evt     (src_evt),
    .clr_en  (take && !pick_trap),
    .clr_idx (a_idx),
    .pend    (s_pend),
    .ena     (s_ena),
    .lvl     (s_lvl)
  );

  ic_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
    .pend (s_pend), .ena (s_ena), .lvl (s_lvl),
    .found (a_found), .win_idx (a_idx), .win_lvl (a_lvl)
  );

  ic_trap_unit u_trap (
    .clk, .rst_n,
    .evt   (trap_evt),
    .clr   (trap_clr),
    .ack   (take && pick_trap),
    .flags (trap_flags),
    .found (t_found),
    .is_urgent (t_urgent),
    .num   (t_num)
  );

  ic_prio_stack #(.W(RW), .DEPTH(STK_DEPTH)) u_stk (
    .clk, .rst_n,
    .push  (take),
    .pop   (do_ret),
    .din   (prio_q),
    .dout  (stk_top),
    .empty (stk_empty)
  );

  // candidate: any pending trap outranks every peripheral level
  always_comb begin
    pick_trap = t_found;
    if (t_found) pick_lvl = t_urgent ? URGENT_LVL : FAULT_LVL;
    else         pick_lvl = {1'b0, a_lvl};
    irq_req = (t_found || a_found) && (pick_lvl > prio_q);
    if (t_found) irq_num = NUM_W'(t_num);
    else         irq_num = NUM_W'(SRC_BASE) + NUM_W'(a_idx);
  end

  assign irq_is_trap = irq_req && pick_trap;
  assign irq_vec     = {irq_num, 2'b00};
  assign take        = irq_ack && irq_req;
  assign do_ret      = irq_ret && !take && !stk_empty;

  always_comb begin
    prio_d = prio_q;
    if (take)        prio_d = pick_lvl;
    else if (do_ret) prio_d = stk_top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= prio_d;
  end

  assign cpu_prio  = prio_q;
  assign reg_rdata = {s_pend[reg_addr], s_ena[reg_addr], 2'b00, s_lvl[reg_addr]};
endmodule

// File: rtl/ic_ctrl_chk.sv
module ic_ctrl_chk #(
  parameter int LVL_W = 4,
  parameter int NUM_W = 6,
  parameter int NT    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic             irq_is_trap,
  input logic             irq_ack,
  input logic [NUM_W-1:0] irq_num,
  input logic [NUM_W+1:0] irq_vec,
  input logic [LVL_W:0]   cpu_prio,
  input logic [LVL_W:0]   pick_lvl,
  input logic [NT-1:0]    trap_flags,
  input logic [NT-1:0]    trap_clr
);
  // R5: an offered request always sits strictly above the running level
  a_r5_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pick_lvl > cpu_prio));

  // R7: acknowledge moves the running level to the accepted level
  a_r7_ack_loads_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (cpu_prio == $past(pick_lvl)));

  // R6: peripheral vectors stay inside the peripheral window
  a_r6_vec_window: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_is_trap) |-> (irq_vec >= (NUM_W+2)'(64)));

  // R9: traps use trap numbers below the peripheral range
  a_r9_trap_num_low: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_is_trap) |-> (irq_num < NUM_W'(16)));

  // R10: during any trap service only traps may be offered
  a_r10_trap_shields: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_prio[LVL_W] && irq_req) |-> irq_is_trap);

  // R11: set flags survive unless cleared
  a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_clr == '0) |=> ((trap_flags & $past(trap_flags)) == $past(trap_flags)));
endmodule

bind ic_ctrl ic_ctrl_chk #(.LVL_W(LVL_W), .NUM_W(NUM_W), .NT(ic_pkg::TRAP_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .irq_is_trap(irq_is_trap),
  .irq_ack    (irq_ack),
  .irq_num    (irq_num),
  .irq_vec    (irq_vec),
  .cpu_prio   (cpu_prio),
  .pick_lvl   (pick_lvl),
  .trap_flags (trap_flags),
  .trap_clr   (trap_clr)
);

// File: tb/ic_ctrl_test.sv
module ic_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] src_evt = '0;
  logic [7:0]  trap_evt = '0;
  logic [7:0]  trap_clr = '0;
  logic [7:0]  trap_flags;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic        irq_req, irq_is_trap;
  logic [5:0]  irq_num;
  logic [7:0]  irq_vec;
  logic [4:0]  cpu_prio;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ic_ctrl uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int idx);
    reg_addr = 5'(idx);
    #1;
  endtask

  task automatic evt(input int idx);
    @(negedge clk); src_evt[idx] = 1'b1;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic trap(input logic [7:0] m, input logic [7:0] c);
    @(negedge clk); trap_evt = m; trap_clr = c;
    @(negedge clk); trap_evt = '0; trap_clr = '0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic expect_irq(input string tag, input int num, input int is_trap);
    chk({tag, " req"}, int'(irq_req), 1);
    chk({tag, " num"}, int'(irq_num), num);
    chk({tag, " vec"}, int'(irq_vec), num * 4);
    chk({tag, " trap"}, int'(irq_is_trap), is_trap);
  endtask

  // row: {check, source, control word, expected req, expected number}
  localparam int NROW = 9;
  localparam logic [20:0] TAB [NROW] = '{
    {1'b1, 5'd3,  8'hC5, 1'b1, 6'h13},  // R4 single source
    {1'b1, 5'd7,  8'hC5, 1'b1, 6'h13},  // R4 tie: lower index stays
    {1'b1, 5'd20, 8'hC9, 1'b1, 6'h24},  // R4 higher level wins
    {1'b1, 5'd20, 8'h89, 1'b1, 6'h13},  // R3 disabled but pending
    {1'b1, 5'd3,  8'h05, 1'b1, 6'h17},  // R4 next in line
    {1'b1, 5'd7,  8'h00, 1'b0, 6'h00},  // R3 only disabled pending left
    {1'b1, 5'd31, 8'hC0, 1'b0, 6'h00},  // R5 level 0 never offered
    {1'b1, 5'd31, 8'hC1, 1'b1, 6'h2F},  // R6 top source vector 0xBC
    {1'b1, 5'd31, 8'h00, 1'b0, 6'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0);
    chk("R1 rdata", int'(reg_rdata), 0);
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 cpu_prio", int'(cpu_prio), 0);
    chk("R1 trap_flags", int'(trap_flags), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      logic [20:0] row;
      row = TAB[r];
      wr(int'(row[19:15]), row[14:7]);
      if (row[20]) begin
        chk($sformatf("R4 table row %0d req", r), int'(irq_req), int'(row[6]));
        if (row[6]) begin
          chk($sformatf("R4 table row %0d num", r), int'(irq_num), int'(row[5:0]));
          chk($sformatf("R6 table row %0d vec", r), int'(irq_vec), int'(row[5:0]) * 4);
        end
      end
    end

    // R2 readback and layout
    rd(20); chk("R2 readback src20", int'(reg_rdata), 'h89);
    wr(10, 8'hFF); rd(10); chk("R2 unused bits read 0", int'(reg_rdata), 'hCF);
    wr(10, 8'h00);

    // R3 event sets pending
    wr(5, 8'h43);
    evt(5);
    expect_irq("R3 event src5", 'h15, 0);
    rd(5); chk("R3 flag set", int'(reg_rdata), 'hC3);

    // R7 acknowledge
    ack();
    chk("R7 cpu_prio after ack", int'(cpu_prio), 3);
    rd(5); chk("R7 flag cleared", int'(reg_rdata), 'h43);
    chk("R7 no request left", int'(irq_req), 0);
    ack();
    chk("R7 idle ack ignored", int'(cpu_prio), 3);

    // R5 equal level held, higher nests; R8 unwinding
    wr(6, 8'hC3);
    chk("R5 equal level held", int'(irq_req), 0);
    wr(8, 8'hC4);
    expect_irq("R5 higher level", 'h18, 0);
    ack();
    chk("R7 nested prio", int'(cpu_prio), 4);
    ret();
    chk("R8 pop to 3", int'(cpu_prio), 3);
    chk("R8 equal still held", int'(irq_req), 0);
    ret();
    chk("R8 pop to 0", int'(cpu_prio), 0);
    expect_irq("R8 released src6", 'h16, 0);
    ack(); ret();
    chk("R8 back to 0", int'(irq_req), 0);
    ret();
    chk("R8 empty pop ignored", int'(cpu_prio), 0);

    // R9 urgent traps
    wr(1, 8'hCF);
    expect_irq("R9 periph before trap", 'h11, 0);
    trap(8'h01, 8'h00);
    expect_irq("R9 nmi", 2, 1);
    chk("R11 flag nmi", int'(trap_flags), 'h01);
    trap(8'h06, 8'h00);
    expect_irq("R9 lowest urgent first", 2, 1);
    ack();
    chk("R9 urgent prio", int'(cpu_prio), 17);
    chk("R9 same group held", int'(irq_req), 0);
    ret();
    expect_irq("R9 stack overflow", 4, 1);
    ack(); ret();
    expect_irq("R9 stack underflow", 6, 1);
    ack(); ret();
    expect_irq("R9 periph resumes", 'h11, 0);

    // R10 fault group and nesting
    trap(8'h48, 8'h00);
    expect_irq("R10 fault shared", 'h0A, 1);
    ack();
    chk("R10 fault prio", int'(cpu_prio), 16);
    chk("R10 all faults cleared, periph blocked", int'(irq_req), 0);
    trap(8'h02, 8'h00);
    expect_irq("R10 urgent preempts fault", 4, 1);
    ack();
    chk("R10 nested prio", int'(cpu_prio), 17);
    trap(8'h80, 8'h00);
    chk("R10 fault held in urgent", int'(irq_req), 0);
    ret();
    chk("R10 back in fault", int'(cpu_prio), 16);
    chk("R10 fault held in fault", int'(irq_req), 0);
    ret();
    expect_irq("R10 fault released", 'h0A, 1);
    ack(); ret();
    expect_irq("R10 periph after faults", 'h11, 0);

    // R11 flag register
    chk("R11 flags collected", int'(trap_flags), 'hCF);
    trap(8'h00, 8'h0F);
    chk("R11 clear low bits", int'(trap_flags), 'hC0);
    trap(8'h40, 8'h40);
    chk("R11 event beats clear", int'(trap_flags), 'hC0);
    trap(8'h00, 8'h80);
    chk("R11 clear bit7", int'(trap_flags), 'h40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule